// File: doc/BRIEF.md
# Receive Message Queue with Private Staging Buffer

This block stores received CAN-style messages until software collects them. While a frame is on the wire, the receiver writes its bytes one at a time into a staging buffer that only the receiver can write. The acceptance decision is made while those bytes arrive. At end of frame, the receiver reports two things: whether the frame ended without error, and whether it passed the identifier filter. Only a frame that has both is copied into a five-slot first-in first-out store. Any other frame leaves the store unchanged, and the next frame overwrites the staging buffer.

Software reads messages through one fixed 15-byte read window. The window always shows the oldest stored message. Byte layout in an entry:

| Bytes | Contents |
|-------|----------|
| 0-3 | identifier |
| 4 | control |
| 5-12 | payload |
| 13 (high) and 14 (low) | 16-bit timestamp |

A message-pending flag tells software when the window holds a message. Software pulses a release input to give the entry back, and the next stored message then moves into the window. If an accepted frame arrives while all five slots are full, the frame is dropped and a sticky overrun flag is raised.

The receiver's byte-write port has no back-pressure, because a bit-level receiver cannot stall. Every strobed byte lands in the staging buffer in the cycle it is presented, so the port carries a valid strobe and no ready.

Top module: `rxq_top`

## Requirements
- R1: After reset, `rxf` is 0, `ovr` is 0 and `rd_data` is 0.
- R2: An end-of-frame strobe with `eof_ok`=1 and `filt_hit`=1, while a slot is free, stores the staging buffer. From the next cycle, `rxf` is 1, and `rd_data` at address k returns the byte last written at staging address k.
- R3: An end-of-frame strobe with `filt_hit`=0 leaves the store, `rxf` and the read window unchanged.
- R4: An end-of-frame strobe with `eof_ok`=0 leaves the store, `rxf` and the read window unchanged.
- R5: Messages leave in arrival order. A `rel` pulse while `rxf`=1 removes the window entry. `rxf` stays 1 while entries remain and drops to 0 in the cycle after the last entry is released.
- R6: The store holds five entries. An accepted frame that arrives when all five are occupied, with no release in the same cycle, is discarded and sets `ovr`. The five stored entries are not affected.
- R7: `ovr` stays at 1 until an `ovr_clr` pulse clears it. When a new overrun occurs in the same cycle as `ovr_clr`, setting wins.
- R8: When `ts_en`=1 at end of frame, entry bytes 13 and 14 hold the high and low bytes of a 16-bit timer. The timer is 0 during reset and adds one every clock after reset. With `ts_en`=0, those bytes hold the staged bytes.
- R9: A `rel` pulse while `rxf`=0 has no effect. A frame stored afterwards appears intact in the window.
- R10: `rd_data` is 0 when `rd_addr` is 15 or above, and whenever `rxf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Staging byte write strobe |
| wr_addr | input | 4 | Staging byte address (0 to 14) |
| wr_data | input | 8 | Staging byte value |
| eof_valid | input | 1 | End-of-frame strobe, one cycle |
| eof_ok | input | 1 | Frame ended without error (qualifies `eof_valid`) |
| filt_hit | input | 1 | Frame passed the acceptance filter (qualifies `eof_valid`) |
| ts_en | input | 1 | Replace bytes 13 and 14 with the timer at end of frame |
| rd_addr | input | 4 | Read window byte address |
| rd_data | output | 8 | Byte of the oldest stored message (combinational) |
| rel | input | 1 | Release the window entry (write-1-to-clear of `rxf`) |
| rxf | output | 1 | Message pending in the read window |
| ovr_clr | input | 1 | Clear the overrun flag |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The properties assume three things about the receiver:
- It never raises `wr_valid` in the same cycle as `eof_valid`.
- It holds `eof_ok` and `filt_hit` stable only for the end-of-frame cycle that they qualify.
- It treats each end-of-frame strobe as a single-cycle pulse.

The directed stimulus follows these rules. It writes all fifteen staging bytes in separate cycles. It then spends one idle cycle on the end-of-frame pulse, and drops every control pulse in the following cycle. Releases and overrun clears are issued only in cycles without an end-of-frame strobe, so simultaneous push and pop is not exercised by the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [7:0] byte_t;

  // Outcome of one end-of-frame event
  typedef enum logic [1:0] {
    FATE_IDLE,
    FATE_DROP,
    FATE_PUSH,
    FATE_OVERRUN
  } fate_e;
endpackage

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/rxq_bgbuf.sv
module rxq_bgbuf
  import rxq_pkg::*;
#(
  parameter int unsigned NBYTES = 15,
  parameter int unsigned TS_W   = 16,
  localparam int unsigned AW    = $clog2(NBYTES),
  localparam int unsigned TSB   = TS_W / 8,
  localparam int unsigned TBASE = NBYTES - TSB
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [AW-1:0]         wr_addr,
  input  byte_t                 wr_data,
  input  logic                  ts_en,
  input  logic [TS_W-1:0]       ts_val,
  output logic [NBYTES*8-1:0]   frame
);
  byte_t stage [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage[i] <= '0;
      else if (wr_valid && (wr_addr == AW'(i)))
        stage[i] <= wr_data;
    end

    if (i >= TBASE) begin : g_ts
      localparam int unsigned J = i - TBASE;
      assign frame[i*8 +: 8] = ts_en ? ts_val[(TSB-1-J)*8 +: 8] : stage[i];
    end else begin : g_plain
      assign frame[i*8 +: 8] = stage[i];
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned NBYTES = 15,
  localparam int unsigned AW    = $clog2(NBYTES),
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [NBYTES*8-1:0] push_data,
  input  logic                pop,
  input  logic [AW-1:0]       rd_addr,
  output byte_t               rd_data,
  output logic [CW-1:0]       count
);
  logic [NBYTES*8-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NBYTES*8-1:0] head;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[s] <= '0;
      else if (push && (wp == PW'(s)))
        slots[s] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = slots[rp];

  always_comb begin
    rd_data = '0;
    if (count != '0) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (rd_addr == AW'(i)) rd_data = head[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned NBYTES = 15,
  parameter int unsigned TS_W   = 16,
  localparam int unsigned AW    = $clog2(NBYTES),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          eof_valid,
  input  logic          eof_ok,
  input  logic          filt_hit,
  input  logic          ts_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          rel,
  output logic          rxf,
  input  logic          ovr_clr,
  output logic          ovr
);
  logic [TS_W-1:0]     ts_now;
  logic [NBYTES*8-1:0] staged;
  logic [CW-1:0]       count;
  logic                pop, has_room;
  fate_e               fate;

  rxq_timer #(.TS_W(TS_W)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .now (ts_now)
  );

  rxq_bgbuf #(.NBYTES(NBYTES), .TS_W(TS_W)) u_bg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ts_en    (ts_en),
    .ts_val   (ts_now),
    .frame    (staged)
  );

  assign rxf      = (count != '0);
  assign pop      = rel && rxf;
  assign has_room = (count < CW'(DEPTH)) || pop;

  always_comb begin
    if (!eof_valid)               fate = FATE_IDLE;
    else if (!(eof_ok && filt_hit)) fate = FATE_DROP;
    else if (has_room)            fate = FATE_PUSH;
    else                          fate = FATE_OVERRUN;
  end

  rxq_store #(.DEPTH(DEPTH), .NBYTES(NBYTES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fate == FATE_PUSH),
    .push_data (staged),
    .pop       (pop),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .count     (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovr <= 1'b0;
    else if (fate == FATE_OVERRUN) ovr <= 1'b1;
    else if (ovr_clr)              ovr <= 1'b0;
  end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int unsigned NBYTES = 15,
  localparam int unsigned AW    = $clog2(NBYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eof_valid,
  input logic          eof_ok,
  input logic          filt_hit,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          rel,
  input logic          rxf,
  input logic          ovr_clr,
  input logic          ovr
);
  logic good_eof;
  assign good_eof = eof_valid && eof_ok && filt_hit;

  // R2
  rxf_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_eof |=> rxf);

  // R3
  reject_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxf && eof_valid && !good_eof) |=> !rxf);

  // R5
  hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf && !rel) |=> rxf);

  // R6
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(good_eof));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !good_eof) |=> !ovr);

  // R10
  window_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rd_addr} >= (AW+1)'(NBYTES)) |-> (rd_data == 8'h00));

  // R10
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxf |-> (rd_data == 8'h00));
endmodule

bind rxq_top rxq_chk #(.NBYTES(NBYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eof_valid (eof_valid),
  .eof_ok    (eof_ok),
  .filt_hit  (filt_hit),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rel       (rel),
  .rxf       (rxf),
  .ovr_clr   (ovr_clr),
  .ovr       (ovr)
);

// File: tb/rxq_top_bench.sv
module rxq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       eof_valid = 1'b0, eof_ok = 1'b0, filt_hit = 1'b0, ts_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rel = 1'b0, rxf, ovr_clr = 1'b0, ovr;

  int checks = 0;
  int errors = 0;
  logic [15:0] tcnt;
  logic [15:0] last_ts;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 16'd1;

  rxq_top u_rxq_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .eof_valid(eof_valid), .eof_ok(eof_ok),
    .filt_hit(filt_hit), .ts_en(ts_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rel(rel), .rxf(rxf), .ovr_clr(ovr_clr), .ovr(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] seed, input bit ok, input bit hit, input bit ts);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 4'(i); wr_data = seed + 8'(i);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    eof_valid = 1'b1; eof_ok = ok; filt_hit = hit; ts_en = ts;
    last_ts = tcnt;
    @(negedge clk);
    eof_valid = 1'b0; eof_ok = 1'b0; filt_hit = 1'b0; ts_en = 1'b0;
  endtask

  task automatic release_head();
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
  endtask

  task automatic check_head(input string req, input logic [7:0] seed,
                            input bit ts, input logic [15:0] tsv);
    logic [7:0] exp;
    for (int i = 0; i < 15; i++) begin
      rd_addr = 4'(i);
      #1;
      exp = seed + 8'(i);
      if (ts && i == 13) exp = tsv[15:8];
      if (ts && i == 14) exp = tsv[7:0];
      chk(rd_data == exp, req, rd_data, exp);
    end
    rd_addr = '0;
  endtask

  task automatic t_reset();
    #1;
    chk(rxf == 1'b0, "R1 rxf", rxf, 0);
    chk(ovr == 1'b0, "R1 ovr", ovr, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_basic();
    send_frame(8'h10, 1, 1, 0);
    chk(rxf == 1'b1, "R2 rxf", rxf, 1);
    check_head("R2 bytes", 8'h10, 0, '0);
    rd_addr = 4'd15; #1;
    chk(rd_data == 8'h00, "R10 addr15", rd_data, 0);
    rd_addr = '0;
    release_head();
    chk(rxf == 1'b0, "R5 last release", rxf, 0);
    chk(rd_data == 8'h00, "R10 empty read", rd_data, 0);
  endtask

  task automatic t_reject();
    send_frame(8'h40, 1, 0, 0);
    chk(rxf == 1'b0, "R3 filter miss", rxf, 0);
    send_frame(8'h50, 0, 1, 0);
    chk(rxf == 1'b0, "R4 frame error", rxf, 0);
    release_head();
    chk(rxf == 1'b0, "R9 rel when empty", rxf, 0);
    send_frame(8'h60, 1, 1, 0);
    chk(rxf == 1'b1, "R9 rxf after push", rxf, 1);
    check_head("R9 intact", 8'h60, 0, '0);
    send_frame(8'h70, 1, 0, 0);
    check_head("R3 window unchanged", 8'h60, 0, '0);
    send_frame(8'h78, 0, 1, 0);
    check_head("R4 window unchanged", 8'h60, 0, '0);
    release_head();
    chk(rxf == 1'b0, "R5 drained", rxf, 0);
  endtask

  task automatic t_order_ts();
    logic [15:0] ts_b;
    send_frame(8'h80, 1, 1, 0);
    send_frame(8'h90, 1, 1, 1);
    ts_b = last_ts;
    send_frame(8'hA0, 1, 1, 0);
    check_head("R5 first", 8'h80, 0, '0);
    release_head();
    chk(rxf == 1'b1, "R5 still pending", rxf, 1);
    check_head("R8 timestamp", 8'h90, 1, ts_b);
    release_head();
    check_head("R5 third", 8'hA0, 0, '0);
    release_head();
    chk(rxf == 1'b0, "R5 empty", rxf, 0);
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 5; k++) send_frame(8'(8'h20 * k + 8'h03), 1, 1, 0);
    chk(ovr == 1'b0, "R6 five fit", ovr, 0);
    send_frame(8'hEE, 1, 1, 0);
    chk(ovr == 1'b1, "R6 overrun set", ovr, 1);
    for (int k = 0; k < 5; k++) begin
      chk(rxf == 1'b1, "R6 entry pending", rxf, 1);
      check_head("R6 order kept", 8'(8'h20 * k + 8'h03), 0, '0);
      release_head();
    end
    chk(rxf == 1'b0, "R6 sixth discarded", rxf, 0);
    chk(ovr == 1'b1, "R7 sticky", ovr, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(ovr == 1'b0, "R7 cleared", ovr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_reject();
    t_order_ts();
    t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule